// File: doc/BRIEF.md
# Sense-Reversing Counter Barrier

This unit lets a fixed group of processors meet at a common point before any of them goes on. Each processor raises its arrive strobe for one cycle. With the strobe it presents its local sense, which is the inverse of the global sense it last saw. Every valid arrival takes one unit off a shared down-counter. Several arrivals in the same cycle take off as many units as there are strobes. While the counter has not reached zero, each processor that has arrived sees its release output held low.

When the arrivals of one cycle bring the counter to zero, the episode ends on that clock edge. The global sense inverts, the counter reloads to the processor count, and the arrival record clears. A processor is free again when the global sense matches the sense it latched on arrival. Because the sense flips on every episode, the same counter serves the next barrier without a separate reset phase. A processor that strobes a second time before its episode completes receives a one-cycle error pulse, and that strobe is not counted.

There is no data stream here, so every pin is a plain control or status signal with no back-pressure. A processor must present a local sense equal to the inverse of `global_sense` when it arrives.

Top module: `barrier_sense_unit`

## Requirements
- R1: After reset the counter holds N (8), `global_sense` is 0, all `release_o` bits are 1 and `dup_err` is 0.
- R2: Each first arrival of a processor in an episode lowers the counter by one, so with single arrivals the episode completes on exactly the Nth distinct arrival.
- R3: Arrivals in the same cycle are all counted; k strobes lower the counter by k in one edge.
- R4: From the edge that registers its arrival until the edge that completes the episode, a processor's `release_o` bit is 0, so no processor is released before all N have arrived.
- R5: On the edge where the arrivals bring the counter to zero, `global_sense` inverts and the counter reloads to N on that same edge.
- R6: `release_o[i]` is 1 exactly when processor i is not waiting and its latched sense equals `global_sense`.
- R7: A strobe from a processor that has already arrived in the current episode gives a one-cycle `dup_err[i]` pulse after that edge, and it neither lowers the counter nor changes the latched sense.
- R8: An arrival in the cycle right after completion counts toward the new episode.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| arrive | input | N | One-cycle arrival strobe per processor |
| arrive_sense | input | N | Local sense per processor, sampled with its strobe |
| release_o | output | N | High when the processor may proceed |
| global_sense | output | 1 | Episode sense, inverted at each completion |
| dup_err | output | N | One-cycle pulse for a repeated arrival |

## Verification
A counter that is off by even one shows up at the ports within one episode. The sense either flips one arrival early, while some `release_o` bit is still low for a processor that has not arrived, or it flips one arrival late and the release is missing. A stale arrival record shows up in the first cycle of the next episode, either as a spurious `dup_err` pulse or as a repeat arrival that is wrongly counted. The bench compares `release_o`, `global_sense` and `dup_err` after every edge against its own model, so any of these faults is caught on the edge where it first appears.

// File: rtl/barrier_pkg.sv
package barrier_pkg;
  typedef enum logic {SENSE_LO = 1'b0, SENSE_HI = 1'b1} sense_e;
endpackage

// File: rtl/barrier_popcount.sv
module barrier_popcount #(
  parameter int N_P = 8,
  parameter int CW  = 4
) (
  input  logic [N_P-1:0] bits_i,
  output logic [CW-1:0]  ones_o
);
  logic [CW-1:0] part [N_P+1];
  assign part[0] = '0;
  for (genvar g = 0; g < N_P; g++) begin : g_add
    assign part[g+1] = part[g] + CW'(bits_i[g]);
  end
  assign ones_o = part[N_P];
endmodule

// File: rtl/barrier_arrival_track.sv
module barrier_arrival_track #(
  parameter int N_P = 8
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic [N_P-1:0] arrive,
  input  logic [N_P-1:0] arrive_sense,
  input  logic           episode_done,
  output logic [N_P-1:0] valid_o,
  output logic [N_P-1:0] arrived_q,
  output logic [N_P-1:0] lsense_q,
  output logic [N_P-1:0] dup_err_q
);
  for (genvar g = 0; g < N_P; g++) begin : g_proc
    assign valid_o[g] = arrive[g] & ~arrived_q[g];

    always_ff @(posedge clk) begin
      if (!rst_n) begin
        arrived_q[g] <= 1'b0;
        lsense_q[g]  <= 1'b0;
        dup_err_q[g] <= 1'b0;
      end else begin
        dup_err_q[g] <= arrive[g] & arrived_q[g];
        if (valid_o[g]) lsense_q[g] <= arrive_sense[g];
        if (episode_done)    arrived_q[g] <= 1'b0;
        else if (valid_o[g]) arrived_q[g] <= 1'b1;
      end
    end
  end
endmodule

// File: rtl/barrier_count_core.sv
module barrier_count_core #(
  parameter int N_P = 8,
  parameter int CW  = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [CW-1:0] n_valid,
  output logic          done_o,
  output logic [CW-1:0] cnt_q,
  output logic          gsense_q
);
  import barrier_pkg::*;
  localparam logic [CW-1:0] RELOAD = CW'(N_P);

  assign done_o = (n_valid == cnt_q);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt_q    <= RELOAD;
      gsense_q <= SENSE_LO;
    end else if (done_o) begin
      cnt_q    <= RELOAD;
      gsense_q <= ~gsense_q;
    end else begin
      cnt_q <= cnt_q - n_valid;
    end
  end
endmodule

// File: rtl/barrier_sense_unit.sv
module barrier_sense_unit #(
  parameter int N_P = 8,
  parameter int CW  = 4
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic [N_P-1:0] arrive,
  input  logic [N_P-1:0] arrive_sense,
  output logic [N_P-1:0] release_o,
  output logic           global_sense,
  output logic [N_P-1:0] dup_err
);
  logic [N_P-1:0] valid;
  logic [N_P-1:0] arrived_q;
  logic [N_P-1:0] lsense_q;
  logic [CW-1:0]  n_valid;
  logic [CW-1:0]  cnt_q;
  logic           done;

  barrier_popcount #(.N_P(N_P), .CW(CW)) u_pop (
    .bits_i(valid), .ones_o(n_valid)
  );

  barrier_arrival_track #(.N_P(N_P)) u_track (
    .clk(clk), .rst_n(rst_n), .arrive(arrive), .arrive_sense(arrive_sense),
    .episode_done(done), .valid_o(valid), .arrived_q(arrived_q),
    .lsense_q(lsense_q), .dup_err_q(dup_err)
  );

  barrier_count_core #(.N_P(N_P), .CW(CW)) u_core (
    .clk(clk), .rst_n(rst_n), .n_valid(n_valid), .done_o(done),
    .cnt_q(cnt_q), .gsense_q(global_sense)
  );

  for (genvar g = 0; g < N_P; g++) begin : g_rel
    assign release_o[g] = ~arrived_q[g] & (lsense_q[g] == global_sense);
  end
endmodule

// File: rtl/barrier_sense_chk.sv
module barrier_sense_chk #(
  parameter int N_P = 8,
  parameter int CW  = 4
) (
  input logic           clk,
  input logic           rst_n,
  input logic [N_P-1:0] arrive,
  input logic [N_P-1:0] release_o,
  input logic           global_sense,
  input logic [N_P-1:0] dup_err,
  input logic [N_P-1:0] arrived_q,
  input logic [CW-1:0]  cnt_q
);
  // R2: counter stays within 1..N
  p_count_bounds_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt_q != '0) && (int'(cnt_q) <= N_P));

  // R3: without completion, counter drops by the number of new arrivals
  p_count_step_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (global_sense == $past(global_sense)) |->
      (int'(cnt_q) == int'($past(cnt_q)) - $countones($past(arrive & ~arrived_q))));

  // R4: a release bit falls only after that processor strobed
  p_hold_until_done_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (~release_o & $past(release_o) & ~$past(arrive)) == '0);

  // R5: a sense flip comes with a full reload and a clear record
  p_reload_on_flip_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (global_sense != $past(global_sense)) |-> (int'(cnt_q) == N_P && arrived_q == '0));

  // R7: error pulses only for a strobe from an already arrived processor
  p_dup_source_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (dup_err & ~$past(arrive & arrived_q)) == '0);
endmodule

bind barrier_sense_unit barrier_sense_chk #(.N_P(N_P), .CW(CW)) u_chk (
  .clk(clk), .rst_n(rst_n), .arrive(arrive), .release_o(release_o),
  .global_sense(global_sense), .dup_err(dup_err),
  .arrived_q(arrived_q), .cnt_q(cnt_q)
);

// File: tb/test_barrier_sense_unit.sv
module test_barrier_sense_unit;
  localparam int N = 8;

  typedef struct {
    logic [N-1:0] rel;
    logic         gs;
    logic [N-1:0] err;
    string        tag;
  } exp_t;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic [N-1:0] arrive = '0;
  logic [N-1:0] arrive_sense = '0;
  logic [N-1:0] release_o;
  logic         global_sense;
  logic [N-1:0] dup_err;

  int tests = 0;
  int fails = 0;
  bit done_flag = 0;
  exp_t q[$];

  logic [N-1:0] m_arr = '0;
  logic [N-1:0] m_ls  = '0;
  logic         m_gs  = 1'b0;
  int           m_cnt = N;

  always #10 clk = ~clk;

  barrier_sense_unit #(.N_P(N), .CW(4)) i_barrier_sense_unit (
    .clk(clk), .rst_n(rst_n), .arrive(arrive), .arrive_sense(arrive_sense),
    .release_o(release_o), .global_sense(global_sense), .dup_err(dup_err)
  );

  task automatic check(input string tag, input logic [N-1:0] r, input logic g,
                       input logic [N-1:0] e, input exp_t x);
    tests++;
    if (r !== x.rel || g !== x.gs || e !== x.err) begin
      fails++;
      $display("FAIL %s: rel=%b gs=%b err=%b expected rel=%b gs=%b err=%b",
               tag, r, g, e, x.rel, x.gs, x.err);
    end
  endtask

  // driver: one call per cycle, drives at negedge and queues the expectation
  task automatic step(input logic [N-1:0] arr, input logic [N-1:0] sns, input string tag);
    logic [N-1:0] valid;
    logic [N-1:0] dup;
    int n;
    exp_t x;
    @(negedge clk);
    arrive = arr;
    arrive_sense = sns;
    valid = arr & ~m_arr;
    dup = arr & m_arr;
    n = $countones(valid);
    for (int i = 0; i < N; i++) if (valid[i]) m_ls[i] = sns[i];
    if (n == m_cnt) begin
      m_gs = ~m_gs;
      m_cnt = N;
      m_arr = '0;
    end else begin
      m_cnt = m_cnt - n;
      m_arr = m_arr | valid;
    end
    for (int i = 0; i < N; i++) x.rel[i] = !m_arr[i] && (m_ls[i] == m_gs);
    x.gs = m_gs;
    x.err = dup;
    x.tag = tag;
    q.push_back(x);
  endtask

  // monitor: compares after each edge
  always @(posedge clk) begin
    #2;
    if (q.size() > 0) begin
      exp_t x;
      x = q.pop_front();
      check(x.tag, release_o, global_sense, dup_err, x);
    end
  end

  initial begin
    exp_t r0;
    repeat (3) @(posedge clk);
    #2;
    r0.rel = '1; r0.gs = 1'b0; r0.err = '0; r0.tag = "R1 reset";
    check("R1 reset", release_o, global_sense, dup_err, r0);
    @(negedge clk);
    rst_n = 1'b1;

    // R2/R4: one at a time with sense 1, release only on the eighth
    for (int i = 0; i < N; i++) step(8'(1) << i, '1, "R2 R4 R5 single arrivals");
    step('0, '0, "R6 released after flip");

    // R3: all at once with sense 0
    step('1, '0, "R3 all simultaneous");
    step('0, '0, "R6 idle after R3");

    // R3: groups of 3 and 5, sense 1
    step(8'b0000_0111, '1, "R3 group of three");
    step(8'b1111_1000, '1, "R3 R5 group of five completes");

    // R7: duplicate in the middle of an episode, sense 0
    step(8'b0000_0011, '0, "R7 first arrivals");
    step(8'b0000_0001, '0, "R7 repeat strobe flagged");
    step(8'b0000_0010, '1, "R7 repeat with other sense ignored");
    step(8'b1111_1100, '0, "R7 R5 completion after repeats");

    // R8: arrival right after completion, sense 1
    step(8'b1111_1110, '1, "R4 seven waiting");
    step(8'b0000_0001, '1, "R5 last completes");
    step(8'b0000_0001, '0, "R8 immediate next episode");
    step(8'b1000_0000, '0, "R8 second arrival");
    step(8'b0111_1110, '0, "R8 R5 episode completes");
    step(8'b0000_0001, '1, "R7 no stale record after completion");
    step('0, '0, "R4 waiting holds");

    @(negedge clk);
    arrive = '0;
    repeat (3) @(posedge clk);
    #5;
    if (!done_flag) begin
      done_flag = 1;
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done_flag) begin
      done_flag = 1;
      tests++;
      fails++;
      $display("FAIL watchdog: run did not end, expected completion");
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end
endmodule